// File: doc/BRIEF.md
# Countdown Timer with APB Register Port

A single-channel down-counting timer for a peripheral bus. Software programs a reload value, then sets an enable bit. From that point the counter decrements by one per clock. When it has sat at zero for one enabled cycle it expires. On expiry it either restarts from the programmed reload value (periodic mode) or wraps to all ones (free-running mode). Free-running mode gives software a long window to re-arm the timer, and reading the inverted count also gives a monotonic time base.

Each expiry sets a sticky event flag. The flag drives one level-sensitive interrupt line unless the mask bit in the control register is set. Software acknowledges by reading an end-of-interrupt register. Only the read is needed; no write is required. The flag is visible both before and after masking, and a fixed version word identifies the block.

Top module: `apb_cdtimer`

## Requirements
- R1: After reset the reload, control, current-count and status registers all read 0, the interrupt output is low and the version register reads 0x3230312A.
- R2: A control write that sets bit 0 (enable) while the timer is disabled loads the counter from the reload register (offset 0x00) on that write's access edge. The counter then falls by one on each following clock, and the count reads at offset 0x04.
- R3: While enable is 0 the counter holds its value.
- R4: With control bit 1 set (periodic), an enabled counter at 0 reloads from the reload register on the next clock and sets the event flag, so the period is reload+1 cycles.
- R5: With control bit 1 clear (free-running), the expiry reload value is 0xFFFFFFFF.
- R6: Control bit 2 is an active-high mask. The interrupt output and the masked status reads (0x10 and 0xA0) equal flag AND NOT mask. The raw status read (0xA8) returns the flag whatever the mask.
- R7: A read of offset 0x0C or 0xA4 clears the event flag and returns 0.
- R8: If an expiry and a clearing read fall on the same clock edge, the flag ends up set.
- R9: Writes to the read-only offsets 0x04, 0x0C, 0x10, 0xA0, 0xA4, 0xA8 and 0xAC change nothing, and the version register at 0xAC returns its constant.
- R10: pready is always 1. Every transfer takes a setup cycle and an access cycle, and its effect lands on the clock edge that ends the access cycle.
- R11: The control register at 0x08 reads back bits 2:0 as written, and all higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock for the bus and the counter |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid in the access cycle |
| pready | output | 1 | Transfer-complete, tied high |
| irq_o | output | 1 | Level interrupt, flag and not mask |

## Verification
The two functions that can fall on one edge are the counter's expiry, which sets the flag, and an acknowledge read, which clears it. The bench arms the counter with a small reload value. It then starts an end-of-interrupt read timed so that the read's access edge is exactly the expiry edge. It judges the result by the interrupt line afterwards: it must stay high, and a second acknowledge must then drop it. Other checks compare count reads against the number of elapsed bus cycles, which the bench counts itself.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam logic [7:0] OFS_RELOAD = 8'h00;
  localparam logic [7:0] OFS_COUNT  = 8'h04;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_ACK    = 8'h0C;
  localparam logic [7:0] OFS_STAT   = 8'h10;
  localparam logic [7:0] OFS_GSTAT  = 8'hA0;
  localparam logic [7:0] OFS_GACK   = 8'hA4;
  localparam logic [7:0] OFS_GRAW   = 8'hA8;
  localparam logic [7:0] OFS_VER    = 8'hAC;

  // control bits: 0 enable, 1 periodic, 2 mask
  typedef struct packed {
    logic mask;
    logic periodic;
    logic en;
  } cdt_ctrl_t;

endpackage

// File: rtl/cdt_apb_regs.sv
module cdt_apb_regs
  import cdt_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] VERSION = 32'h3230_312A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] count_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic [DATA_W-1:0] reload_o,
  output cdt_ctrl_t         ctrl_o,
  output logic              start_o,
  output logic              clr_o
);

  localparam int CTRL_W = $bits(cdt_ctrl_t);

  logic            wr_acc, rd_acc;
  logic [7:0]      ofs;
  logic [DATA_W-1:0] reload_q;
  cdt_ctrl_t       ctrl_q;
  logic            masked;

  assign wr_acc = psel & penable & pwrite;
  assign rd_acc = psel & penable & ~pwrite;
  assign ofs    = 8'(paddr);
  assign masked = flag_i & ~ctrl_q.mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      ctrl_q   <= '0;
    end else if (wr_acc) begin
      if (ofs == OFS_RELOAD) reload_q <= pwdata;
      if (ofs == OFS_CTRL)   ctrl_q   <= cdt_ctrl_t'(pwdata[CTRL_W-1:0]);
    end
  end

  // rising enable written from the bus
  assign start_o = wr_acc & (ofs == OFS_CTRL) & pwdata[0] & ~ctrl_q.en;
  // acknowledge is a read side effect
  assign clr_o   = rd_acc & ((ofs == OFS_ACK) | (ofs == OFS_GACK));

  always_comb begin
    prdata = '0;
    unique case (ofs)
      OFS_RELOAD: prdata = reload_q;
      OFS_COUNT:  prdata = count_i;
      OFS_CTRL:   prdata = DATA_W'(ctrl_q);
      OFS_STAT:   prdata = DATA_W'(masked);
      OFS_GSTAT:  prdata = DATA_W'(masked);
      OFS_GRAW:   prdata = DATA_W'(flag_i);
      OFS_VER:    prdata = DATA_W'(VERSION);
      default:    prdata = '0;
    endcase
  end

  assign pready   = 1'b1;
  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;

  a_r10_ready_high: assert property (@(posedge clk) disable iff (!rst_n) pready);
  a_r11_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && ofs == OFS_CTRL) |=> (ctrl_o == $past(pwdata[CTRL_W-1:0])));
  a_r9_reload_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_acc && ofs == OFS_RELOAD) |=> $stable(reload_o));

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              periodic_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] reload_i,
  output logic [DATA_W-1:0] count_o,
  output logic              expire_o
);

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  function automatic logic [DATA_W-1:0] wrap_value(input logic periodic,
                                                   input logic [DATA_W-1:0] reload);
    return periodic ? reload : ALL_ONES;
  endfunction

  logic [DATA_W-1:0] count_q;
  logic              at_zero;

  assign at_zero  = (count_q == '0);
  assign expire_o = en_i & ~start_i & at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (start_i)  count_q <= reload_i;
    else if (expire_o) count_q <= wrap_value(periodic_i, reload_i);
    else if (en_i)     count_q <= count_q - 1'b1;
  end

  assign count_o = count_q;

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !start_i) |=> $stable(count_o));
  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (count_o == $past(reload_i)));
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !start_i && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));
  a_r4_periodic_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && periodic_i) |=> (count_o == $past(reload_i)));
  a_r5_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !periodic_i) |=> (count_o == ALL_ONES));

endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (expire_i) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ~mask_i;

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> flag_o);
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !expire_i) |=> !flag_o);
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/apb_cdtimer.sv
module apb_cdtimer
  import cdt_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] VERSION = 32'h3230_312A
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              irq_o
);

  logic [DATA_W-1:0] reload_w, count_w;
  cdt_ctrl_t         ctrl_w;
  logic              start_w, clr_w, expire_w, flag_w;

  cdt_apb_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_regs (
    .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .count_i(count_w), .flag_i(flag_w),
    .prdata(prdata), .pready(pready), .reload_o(reload_w), .ctrl_o(ctrl_w),
    .start_o(start_w), .clr_o(clr_w)
  );

  cdt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(pclk), .rst_n(presetn), .en_i(ctrl_w.en), .periodic_i(ctrl_w.periodic),
    .start_i(start_w), .reload_i(reload_w), .count_o(count_w), .expire_o(expire_w)
  );

  cdt_irq u_irq (
    .clk(pclk), .rst_n(presetn), .expire_i(expire_w), .clr_i(clr_w),
    .mask_i(ctrl_w.mask), .flag_o(flag_w), .irq_o(irq_o)
  );

  a_r6_mask_blocks: assert property (@(posedge pclk) disable iff (!presetn)
    ctrl_w.mask |-> !irq_o);
  a_r6_irq_follows_flag: assert property (@(posedge pclk) disable iff (!presetn)
    (flag_w && !ctrl_w.mask) |-> irq_o);

endmodule

// File: tb/sim_apb_cdtimer.sv
`timescale 1ns/1ps
module sim_apb_cdtimer;

  localparam logic [7:0] A_RELOAD = 8'h00, A_COUNT = 8'h04, A_CTRL = 8'h08,
                         A_ACK = 8'h0C, A_STAT = 8'h10, A_GSTAT = 8'hA0,
                         A_GACK = 8'hA4, A_GRAW = 8'hA8, A_VER = 8'hAC;
  localparam logic [31:0] VER_EXP = 32'h3230_312A;

  logic        pclk = 1'b0, presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        pready, irq_o;
  int          n_checks = 0, n_fail = 0;
  logic [31:0] rd;

  always #2.5 pclk = ~pclk;

  apb_cdtimer u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(posedge pclk);
    #0.1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #0.5 d = prdata;
    chk("R10 pready", 32'(pready), 32'd1);
    @(posedge pclk);
    #0.1 psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset;
    bus_rd(A_RELOAD, rd); chk("R1 reload", rd, 0);
    bus_rd(A_CTRL, rd);   chk("R1 ctrl", rd, 0);
    bus_rd(A_COUNT, rd);  chk("R1 count", rd, 0);
    bus_rd(A_GRAW, rd);   chk("R1 raw", rd, 0);
    bus_rd(A_VER, rd);    chk("R1 version", rd, VER_EXP);
    chk("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_start_hold;
    bus_wr(A_RELOAD, 32'd100);
    bus_wr(A_CTRL, 32'd3);                 // loaded on this edge
    bus_rd(A_COUNT, rd); chk("R2 first", rd, 32'd99);
    bus_rd(A_COUNT, rd); chk("R2 second", rd, 32'd97);
    bus_wr(A_CTRL, 32'hFFFF_FFFA);         // enable 0, periodic 1, mask 0
    bus_rd(A_CTRL, rd);  chk("R11 readback", rd, 32'd2);
    bus_rd(A_COUNT, rd); chk("R3 hold a", rd, 32'd94);
    bus_rd(A_COUNT, rd); chk("R3 hold b", rd, 32'd94);
    bus_wr(A_COUNT, 32'h1234);
    bus_rd(A_COUNT, rd); chk("R9 count ro", rd, 32'd94);
    bus_wr(A_GRAW, 32'hFFFF_FFFF);
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    bus_rd(A_GRAW, rd);  chk("R9 raw ro", rd, 0);
    bus_wr(A_VER, 32'h0);
    bus_rd(A_VER, rd);   chk("R9 version ro", rd, VER_EXP);
  endtask

  task automatic t_periodic_mask;
    bus_wr(A_RELOAD, 32'd5);
    bus_wr(A_CTRL, 32'd3);
    for (int k = 1; k <= 7; k++) begin
      @(negedge pclk);
      if (k == 6) chk("R4 before expiry", 32'(irq_o), 0);
      if (k == 7) chk("R4 at expiry", 32'(irq_o), 1);
    end
    bus_rd(A_COUNT, rd); chk("R4 reloaded", rd, 32'd3);
    bus_wr(A_CTRL, 32'd7);
    @(negedge pclk); chk("R6 masked irq", 32'(irq_o), 0);
    bus_rd(A_STAT, rd);  chk("R6 masked stat", rd, 0);
    bus_rd(A_GSTAT, rd); chk("R6 masked gstat", rd, 0);
    bus_rd(A_GRAW, rd);  chk("R6 raw", rd, 1);
    bus_wr(A_CTRL, 32'd3);
    @(negedge pclk); chk("R6 unmasked irq", 32'(irq_o), 1);
    bus_rd(A_STAT, rd);  chk("R6 unmasked stat", rd, 1);
  endtask

  task automatic t_ack;
    bus_wr(A_CTRL, 32'd2);
    bus_rd(A_ACK, rd);   chk("R7 ack data", rd, 0);
    @(negedge pclk); chk("R7 ack irq", 32'(irq_o), 0);
    bus_rd(A_GRAW, rd);  chk("R7 ack raw", rd, 0);
    bus_wr(A_RELOAD, 32'd2);
    bus_wr(A_CTRL, 32'd3);
    repeat (5) @(posedge pclk);
    bus_wr(A_CTRL, 32'd2);
    bus_rd(A_GRAW, rd);  chk("R7 set again", rd, 1);
    bus_rd(A_GACK, rd);  chk("R7 gack data", rd, 0);
    bus_rd(A_GRAW, rd);  chk("R7 gack raw", rd, 0);
  endtask

  task automatic t_free;
    bus_wr(A_RELOAD, 32'd3);
    bus_wr(A_CTRL, 32'd1);
    repeat (4) @(posedge pclk);
    bus_rd(A_COUNT, rd); chk("R5 wrap", rd, 32'hFFFF_FFFE);
    bus_rd(A_GRAW, rd);  chk("R5 flag", rd, 1);
    bus_wr(A_CTRL, 32'd0);
    bus_rd(A_GACK, rd);
  endtask

  task automatic t_coincide;
    bus_wr(A_RELOAD, 32'd4);
    bus_wr(A_CTRL, 32'd3);               // count 4 here, expiry 5 edges later
    repeat (3) @(posedge pclk);
    bus_rd(A_ACK, rd);                     // access edge is the expiry edge
    @(negedge pclk); chk("R8 set wins", 32'(irq_o), 1);
    bus_wr(A_CTRL, 32'd2);
    bus_rd(A_ACK, rd);
    @(negedge pclk); chk("R8 later ack", 32'(irq_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge pclk);
    #1 presetn = 1'b1;
    t_reset();
    t_start_hold();
    t_periodic_mask();
    t_ack();
    t_free();
    t_coincide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule